// File: doc/BRIEF.md
# Network Time-of-Day Counter

This block keeps the running time of a network timestamping unit as a seconds field and a sub-second field. On each reference clock tick it adds a programmable 8-bit sub-second step. The sub-second field wraps into the seconds field at one of two limits. Binary mode wraps at 2^31. Decimal mode wraps at one billion, so that the sub-second field counts nanoseconds.

The block has two stepping methods. In coarse stepping a tick occurs on every clock. In fine stepping a 32-bit accumulator adds a programmable addend on every clock, and a tick occurs only when that addition carries out. Software trims the counter frequency by moving the addend around its reset value of 0x80000000.

Software drives the block through single-cycle strobes:
- An absolute-time load.
- A signed offset, given as seconds, sub-seconds and a sign.
- A new addend.
- A snapshot request, which captures both fields of the time in the same clock edge.

Load and offset requests are staged and applied on the next tick. A busy flag stays high while either request is waiting.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset, the time, the snapshot and busy are all zero, and the addend is 0x80000000.
- R2: With fine stepping off (fine_en_i=0), every clock edge adds sub_inc_i to the sub-second field.
- R3: With roll_dec_i=0 (binary), a sub-second result of 0x80000000 or more wraps. The field takes the result minus 0x80000000, and the seconds field increments, wrapping modulo 2^32.
- R4: With roll_dec_i=1 (decimal), a sub-second result of 1,000,000,000 or more wraps. The field takes the result minus 1,000,000,000, and the seconds field increments.
- R5: With fine_en_i=1, the step is added only on an edge where the 32-bit accumulator plus the addend carries out. With addend 0x80000000, this gives exactly one step every two edges.
- R6: An addend strobe takes effect for the accumulation from the following clock onward. An addend of zero halts the time in fine stepping.
- R7: A load strobe sets busy_o from the next edge. The load is applied on the first tick after that edge, with no step added on that tick, and busy_o falls at that same edge. While no tick occurs, busy_o stays high and the time is unchanged.
- R8: An offset with adj_neg_i=0 adds the seconds and the sub-seconds. A sub-second sum at or above the active limit wraps and carries one extra second.
- R9: An offset with adj_neg_i=1 subtracts the seconds and the sub-seconds. A sub-second borrow adds the active limit to the sub-second field and takes one extra second, and the seconds field wraps modulo 2^32.
- R10: If a load and an offset are both waiting when a tick occurs, only the load is applied and the offset is discarded.
- R11: A snapshot strobe captures the time present before the capturing edge, with both fields taken from the same edge. The captured value is held until the next snapshot strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| roll_dec_i | input | 1 | 1 = decimal wrap at 10^9, 0 = binary wrap at 2^31 |
| fine_en_i | input | 1 | 1 = addend-gated stepping, 0 = step on every clock |
| sub_inc_i | input | INC_W | Sub-second step per tick |
| set_stb_i | input | 1 | Absolute-time load strobe |
| set_sec_i | input | SEC_W | Seconds value to load |
| set_sub_i | input | 32 | Sub-seconds value to load |
| adj_stb_i | input | 1 | Offset strobe |
| adj_neg_i | input | 1 | Offset sign, 1 = subtract |
| adj_sec_i | input | SEC_W | Offset seconds |
| adj_sub_i | input | 32 | Offset sub-seconds (below the active limit) |
| addend_stb_i | input | 1 | Addend load strobe |
| addend_i | input | ACC_W | New addend |
| snap_stb_i | input | 1 | Snapshot strobe |
| snap_sec_o | output | SEC_W | Captured seconds |
| snap_sub_o | output | 32 | Captured sub-seconds |
| busy_o | output | 1 | Load or offset waiting for a tick |
| now_sec_o | output | SEC_W | Live seconds |
| now_sub_o | output | 32 | Live sub-seconds |

## Verification
Coarse stepping is run from loaded start points:
- Runs that stay below a limit confirm that the plain step is added.
- Runs that land exactly on a limit confirm that the comparison is "at or above" and not "above".
- Runs that cross a limit over several edges show which mode's limit is in force.
- A start at the largest seconds value shows that the seconds field wraps.

Fine stepping is measured over windows whose total addend is a multiple of 2^32, so that the step count does not depend on the accumulator phase. These windows separate the nominal addend, a halved addend and a zero addend.

Offsets are applied with the step set to zero, so the offset arithmetic is seen alone. They cover an addition that carries and a subtraction that borrows in each mode, a subtraction with no borrow, and a subtraction that wraps the seconds.

## File: rtl/ptp_tod_pkg.sv
// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

  // Width of the sub-second field; both wrap limits fit below 2^32.
  localparam int SUB_W = 32;

  typedef enum logic {
    ROLL_BIN = 1'b0,
    ROLL_DEC = 1'b1
  } roll_mode_e;

  localparam logic [SUB_W-1:0] BIN_LIMIT = 32'h8000_0000;
  localparam logic [SUB_W-1:0] DEC_LIMIT = 32'd1_000_000_000;

  function automatic logic [SUB_W-1:0] roll_limit(input roll_mode_e m);
    return (m == ROLL_DEC) ? DEC_LIMIT : BIN_LIMIT;
  endfunction

endpackage

// File: rtl/ptp_tod_accum.sv
module ptp_tod_accum #(
  parameter int              ACC_W       = 32,
  parameter logic [ACC_W-1:0] BASE_ADDEND = {1'b1, {(ACC_W-1){1'b0}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine_en,
  input  logic             addend_stb,
  input  logic [ACC_W-1:0] addend_val,
  output logic             tick
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] addend_q, addend_d;
  logic [ACC_W:0]   acc_sum;
  logic             acc_en, addend_en;

  always_comb begin
    acc_sum   = {1'b0, acc_q} + {1'b0, addend_q};
    acc_en    = fine_en;
    acc_d     = acc_sum[ACC_W-1:0];
    addend_en = addend_stb;
    addend_d  = addend_val;
    tick      = fine_en ? acc_sum[ACC_W] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      addend_q <= BASE_ADDEND;
    end else begin
      if (acc_en)    acc_q    <= acc_d;
      if (addend_en) addend_q <= addend_d;
    end
  end

endmodule

// File: rtl/ptp_tod_stage.sv
module ptp_tod_stage #(
  parameter int SEC_W = 32,
  parameter int SUB_W = ptp_tod_pkg::SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             set_stb,
  input  logic [SEC_W-1:0] set_sec,
  input  logic [SUB_W-1:0] set_sub,
  input  logic             adj_stb,
  input  logic             adj_neg,
  input  logic [SEC_W-1:0] adj_sec,
  input  logic [SUB_W-1:0] adj_sub,
  output logic             set_pend,
  output logic [SEC_W-1:0] set_sec_q,
  output logic [SUB_W-1:0] set_sub_q,
  output logic             adj_pend,
  output logic             adj_neg_q,
  output logic [SEC_W-1:0] adj_sec_q,
  output logic [SUB_W-1:0] adj_sub_q,
  output logic             busy
);

  logic set_pend_d, adj_pend_d;

  // A fresh strobe wins over the clearing tick; a tick clears both
  // requests, which drops an offset when a load is applied with it.
  always_comb begin
    set_pend_d = set_stb ? 1'b1 : (tick ? 1'b0 : set_pend);
    adj_pend_d = adj_stb ? 1'b1 : (tick ? 1'b0 : adj_pend);
    busy       = set_pend | adj_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_pend  <= 1'b0;
      adj_pend  <= 1'b0;
      set_sec_q <= '0;
      set_sub_q <= '0;
      adj_neg_q <= 1'b0;
      adj_sec_q <= '0;
      adj_sub_q <= '0;
    end else begin
      set_pend <= set_pend_d;
      adj_pend <= adj_pend_d;
      if (set_stb) begin
        set_sec_q <= set_sec;
        set_sub_q <= set_sub;
      end
      if (adj_stb) begin
        adj_neg_q <= adj_neg;
        adj_sec_q <= adj_sec;
        adj_sub_q <= adj_sub;
      end
    end
  end

endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             roll_dec,
  input  logic [INC_W-1:0] inc,
  input  logic             set_pend,
  input  logic [SEC_W-1:0] set_sec,
  input  logic [SUB_W-1:0] set_sub,
  input  logic             adj_pend,
  input  logic             adj_neg,
  input  logic [SEC_W-1:0] adj_sec,
  input  logic [SUB_W-1:0] adj_sub,
  output logic [SEC_W-1:0] sec_q,
  output logic [SUB_W-1:0] sub_q
);

  localparam int N_MODES = 2;

  logic [SUB_W-1:0] inc_ext;
  logic [SUB_W:0]   step_sum;
  logic [SUB_W-1:0] step_res  [N_MODES];
  logic             step_wrap [N_MODES];

  assign inc_ext  = {{(SUB_W-INC_W){1'b0}}, inc};
  assign step_sum = {1'b0, sub_q} + {1'b0, inc_ext};

  // One wrap evaluator per rollover mode, selected afterwards.
  for (genvar g = 0; g < N_MODES; g++) begin : g_roll
    localparam logic [SUB_W-1:0] LIM = roll_limit(roll_mode_e'(g));
    always_comb begin
      step_wrap[g] = step_sum >= {1'b0, LIM};
      step_res[g]  = step_wrap[g] ? (sub_q + inc_ext - LIM) : (sub_q + inc_ext);
    end
  end

  logic [SUB_W-1:0] lim_sel;
  logic [SUB_W:0]   add_sum;
  logic             add_wrap, sub_borrow;
  logic [SUB_W-1:0] add_res, dif_res;
  logic [SEC_W-1:0] add_sec, dif_sec;
  logic [SEC_W-1:0] sec_d;
  logic [SUB_W-1:0] sub_d;
  logic             time_en;

  always_comb begin
    lim_sel    = roll_limit(roll_mode_e'(roll_dec));
    add_sum    = {1'b0, sub_q} + {1'b0, adj_sub};
    add_wrap   = add_sum >= {1'b0, lim_sel};
    add_res    = add_wrap ? (sub_q + adj_sub - lim_sel) : (sub_q + adj_sub);
    add_sec    = sec_q + adj_sec + {{(SEC_W-1){1'b0}}, add_wrap};
    sub_borrow = sub_q < adj_sub;
    dif_res    = sub_borrow ? (sub_q - adj_sub + lim_sel) : (sub_q - adj_sub);
    dif_sec    = sec_q - adj_sec - {{(SEC_W-1){1'b0}}, sub_borrow};
  end

  always_comb begin
    time_en = tick;
    if (set_pend) begin
      sec_d = set_sec;
      sub_d = set_sub;
    end else if (adj_pend) begin
      sec_d = adj_neg ? dif_sec : add_sec;
      sub_d = adj_neg ? dif_res : add_res;
    end else begin
      sec_d = sec_q + {{(SEC_W-1){1'b0}}, step_wrap[roll_dec]};
      sub_d = step_res[roll_dec];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (time_en) begin
      sec_q <= sec_d;
      sub_q <= sub_d;
    end
  end

endmodule

// File: rtl/ptp_tod_snap.sv
module ptp_tod_snap #(
  parameter int SEC_W = 32,
  parameter int SUB_W = ptp_tod_pkg::SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_stb,
  input  logic [SEC_W-1:0] sec,
  input  logic [SUB_W-1:0] sub,
  output logic [SEC_W-1:0] snap_sec,
  output logic [SUB_W-1:0] snap_sub
);

  logic snap_en;
  assign snap_en = snap_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_sec <= '0;
      snap_sub <= '0;
    end else if (snap_en) begin
      snap_sec <= sec;
      snap_sub <= sub;
    end
  end

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int INC_W = 8,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             roll_dec_i,
  input  logic             fine_en_i,
  input  logic [INC_W-1:0] sub_inc_i,
  input  logic             set_stb_i,
  input  logic [SEC_W-1:0] set_sec_i,
  input  logic [SUB_W-1:0] set_sub_i,
  input  logic             adj_stb_i,
  input  logic             adj_neg_i,
  input  logic [SEC_W-1:0] adj_sec_i,
  input  logic [SUB_W-1:0] adj_sub_i,
  input  logic             addend_stb_i,
  input  logic [ACC_W-1:0] addend_i,
  input  logic             snap_stb_i,
  output logic [SEC_W-1:0] snap_sec_o,
  output logic [SUB_W-1:0] snap_sub_o,
  output logic             busy_o,
  output logic [SEC_W-1:0] now_sec_o,
  output logic [SUB_W-1:0] now_sub_o
);

  // Reset asserts at once and releases two clocks later.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic             tick_w;
  logic             set_pend_w, adj_pend_w, adj_neg_w;
  logic [SEC_W-1:0] set_sec_w, adj_sec_w;
  logic [SUB_W-1:0] set_sub_w, adj_sub_w;

  ptp_tod_accum #(.ACC_W(ACC_W)) u_accum (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fine_en    (fine_en_i),
    .addend_stb (addend_stb_i),
    .addend_val (addend_i),
    .tick       (tick_w)
  );

  ptp_tod_stage #(.SEC_W(SEC_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick_w),
    .set_stb   (set_stb_i),
    .set_sec   (set_sec_i),
    .set_sub   (set_sub_i),
    .adj_stb   (adj_stb_i),
    .adj_neg   (adj_neg_i),
    .adj_sec   (adj_sec_i),
    .adj_sub   (adj_sub_i),
    .set_pend  (set_pend_w),
    .set_sec_q (set_sec_w),
    .set_sub_q (set_sub_w),
    .adj_pend  (adj_pend_w),
    .adj_neg_q (adj_neg_w),
    .adj_sec_q (adj_sec_w),
    .adj_sub_q (adj_sub_w),
    .busy      (busy_o)
  );

  ptp_tod_core #(.SEC_W(SEC_W), .INC_W(INC_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick_w),
    .roll_dec (roll_dec_i),
    .inc      (sub_inc_i),
    .set_pend (set_pend_w),
    .set_sec  (set_sec_w),
    .set_sub  (set_sub_w),
    .adj_pend (adj_pend_w),
    .adj_neg  (adj_neg_w),
    .adj_sec  (adj_sec_w),
    .adj_sub  (adj_sub_w),
    .sec_q    (now_sec_o),
    .sub_q    (now_sub_o)
  );

  ptp_tod_snap #(.SEC_W(SEC_W)) u_snap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .snap_stb (snap_stb_i),
    .sec      (now_sec_o),
    .sub      (now_sub_o),
    .snap_sec (snap_sec_o),
    .snap_sub (snap_sub_o)
  );

endmodule

// File: rtl/ptp_tod_counter_chk.sv
module ptp_tod_counter_chk
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fine_en,
  input logic             roll_dec,
  input logic             set_stb,
  input logic             adj_stb,
  input logic             snap_stb,
  input logic             tick,
  input logic             busy,
  input logic [SEC_W-1:0] now_sec,
  input logic [SUB_W-1:0] now_sub,
  input logic [SEC_W-1:0] snap_sec,
  input logic [SUB_W-1:0] snap_sub
);

  // R2
  coarse_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_en |-> tick);

  // R5
  fine_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_en && !tick) |=> ($stable(now_sec) && $stable(now_sub)));

  // R3
  bin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!roll_dec && !busy && now_sub < BIN_LIMIT) |=> (now_sub < BIN_LIMIT));

  // R4
  dec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_dec && !busy && now_sub < DEC_LIMIT) |=> (now_sub < DEC_LIMIT));

  // R7
  set_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> busy);

  // R8
  adj_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adj_stb |=> busy);

  // R7
  busy_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);

  // R11
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_stb |=> ($stable(snap_sec) && $stable(snap_sub)));

endmodule

bind ptp_tod_counter ptp_tod_counter_chk #(.SEC_W(SEC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .fine_en  (fine_en_i),
  .roll_dec (roll_dec_i),
  .set_stb  (set_stb_i),
  .adj_stb  (adj_stb_i),
  .snap_stb (snap_stb_i),
  .tick     (tick_w),
  .busy     (busy_o),
  .now_sec  (now_sec_o),
  .now_sub  (now_sub_o),
  .snap_sec (snap_sec_o),
  .snap_sub (snap_sub_o)
);

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        roll_dec, fine_en;
  logic [7:0]  inc;
  logic        set_stb, adj_stb, adj_neg, addend_stb, snap_stb;
  logic [31:0] set_sec, set_sub, adj_sec, adj_sub, addend;
  logic [31:0] snap_sec, snap_sub, now_sec, now_sub;
  logic        busy;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ptp_tod_counter dut_i (
    .clk(clk), .rst_n(rst_n), .roll_dec_i(roll_dec), .fine_en_i(fine_en),
    .sub_inc_i(inc), .set_stb_i(set_stb), .set_sec_i(set_sec), .set_sub_i(set_sub),
    .adj_stb_i(adj_stb), .adj_neg_i(adj_neg), .adj_sec_i(adj_sec), .adj_sub_i(adj_sub),
    .addend_stb_i(addend_stb), .addend_i(addend), .snap_stb_i(snap_stb),
    .snap_sec_o(snap_sec), .snap_sub_o(snap_sub), .busy_o(busy),
    .now_sec_o(now_sec), .now_sub_o(now_sub)
  );

  typedef struct packed {
    logic        dec;
    logic [7:0]  stp;
    logic [31:0] sec0;
    logic [31:0] sub0;
    logic [7:0]  cyc;
    logic [31:0] esec;
    logic [31:0] esub;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd8,   32'd5,          32'd0,           8'd10, 32'd5, 32'd80},          // R2
    '{1'b0, 8'd255, 32'd1,          32'h7FFF_FF00,   8'd2,  32'd2, 32'h0000_00FE},   // R3
    '{1'b1, 8'd40,  32'd7,          32'd999_999_960, 8'd1,  32'd8, 32'd0},           // R4
    '{1'b1, 8'd40,  32'd7,          32'd999_999_900, 8'd1,  32'd7, 32'd999_999_940}, // R4
    '{1'b1, 8'd200, 32'd0,          32'd999_999_000, 8'd10, 32'd1, 32'd1000},        // R4
    '{1'b0, 8'd1,   32'hFFFF_FFFF,  32'h7FFF_FFFF,   8'd1,  32'd0, 32'd0}            // R3
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_set(input logic [31:0] s, input logic [31:0] ns);
    @(negedge clk);
    set_stb = 1'b1; set_sec = s; set_sub = ns;
    @(negedge clk);
    set_stb = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic do_adj(input logic neg, input logic [31:0] s, input logic [31:0] ns);
    @(negedge clk);
    adj_stb = 1'b1; adj_neg = neg; adj_sec = s; adj_sub = ns;
    @(negedge clk);
    adj_stb = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic load_addend(input logic [31:0] v);
    @(negedge clk);
    addend_stb = 1'b1; addend = v;
    @(negedge clk);
    addend_stb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    logic [31:0] base;
    rst_n = 1'b0; roll_dec = 1'b0; fine_en = 1'b0; inc = 8'd0;
    set_stb = 1'b0; adj_stb = 1'b0; adj_neg = 1'b0; addend_stb = 1'b0; snap_stb = 1'b0;
    set_sec = '0; set_sub = '0; adj_sec = '0; adj_sub = '0; addend = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 time", {now_sec, now_sub}, 64'd0);
    check("R1 snap", {snap_sec, snap_sub}, 64'd0);
    check("R1 busy", {63'd0, busy}, 64'd0);

    // Vector table: load, then coarse stepping
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      roll_dec = VECS[i].dec; inc = VECS[i].stp;
      set_stb = 1'b1; set_sec = VECS[i].sec0; set_sub = VECS[i].sub0;
      @(negedge clk);
      set_stb = 1'b0;
      check("R7 busy after load", {63'd0, busy}, 64'd1);
      @(negedge clk);
      check("R7 busy cleared", {63'd0, busy}, 64'd0);
      check("R7 loaded value", {now_sec, now_sub}, {VECS[i].sec0, VECS[i].sub0});
      repeat (VECS[i].cyc) @(negedge clk);
      check($sformatf("R2/R3/R4 vector %0d", i), {now_sec, now_sub},
            {VECS[i].esec, VECS[i].esub});
    end

    // R5 fine stepping at nominal addend
    roll_dec = 1'b0; inc = 8'd10;
    do_set(32'd0, 32'd0);
    @(negedge clk);
    fine_en = 1'b1;
    base = now_sub;
    repeat (20) @(negedge clk);
    check("R5 20 edges", {32'd0, now_sub - base}, 64'd100);
    base = now_sub;
    repeat (2) @(negedge clk);
    check("R5 2 edges", {32'd0, now_sub - base}, 64'd10);

    // R6 halved addend: 8 edges give exactly 2 steps
    @(negedge clk);
    addend_stb = 1'b1; addend = 32'h4000_0000;
    @(negedge clk);
    addend_stb = 1'b0;
    base = now_sub;
    repeat (8) @(negedge clk);
    check("R6 halved addend", {32'd0, now_sub - base}, 64'd20);

    // R6 zero addend halts the time
    @(negedge clk);
    addend_stb = 1'b1; addend = 32'h0;
    @(negedge clk);
    addend_stb = 1'b0;
    base = now_sub;
    repeat (10) @(negedge clk);
    check("R6 zero addend", {32'd0, now_sub - base}, 64'd0);

    // R10 load and offset both waiting, no tick yet
    @(negedge clk);
    adj_stb = 1'b1; adj_neg = 1'b0; adj_sec = 32'd1; adj_sub = 32'd0;
    @(negedge clk);
    adj_stb = 1'b0;
    set_stb = 1'b1; set_sec = 32'd77; set_sub = 32'd1234;
    @(negedge clk);
    set_stb = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 busy held without tick", {63'd0, busy}, 64'd1);
    check("R7 time unchanged while waiting", {32'd0, now_sub - base}, 64'd0);
    load_addend(32'h8000_0000);
    while (busy) @(negedge clk);
    check("R10 load wins over offset", {now_sec, now_sub}, {32'd77, 32'd1234});

    // R8/R9 offsets with step zero, coarse stepping
    fine_en = 1'b0; inc = 8'd0;
    roll_dec = 1'b1;
    do_set(32'd10, 32'd999_999_000); do_adj(1'b0, 32'd2, 32'd5000);
    check("R8 dec add carry", {now_sec, now_sub}, {32'd13, 32'd4000});
    roll_dec = 1'b0;
    do_set(32'd3, 32'h7FFF_FFF0); do_adj(1'b0, 32'd0, 32'h20);
    check("R8 bin add carry", {now_sec, now_sub}, {32'd4, 32'h10});
    roll_dec = 1'b1;
    do_set(32'd10, 32'd100); do_adj(1'b1, 32'd1, 32'd300);
    check("R9 dec sub borrow", {now_sec, now_sub}, {32'd8, 32'd999_999_800});
    roll_dec = 1'b0;
    do_set(32'd5, 32'h10); do_adj(1'b1, 32'd0, 32'h20);
    check("R9 bin sub borrow", {now_sec, now_sub}, {32'd4, 32'h7FFF_FFF0});
    roll_dec = 1'b1;
    do_set(32'd5, 32'd500); do_adj(1'b1, 32'd2, 32'd100);
    check("R9 dec sub no borrow", {now_sec, now_sub}, {32'd3, 32'd400});
    do_set(32'd0, 32'd0); do_adj(1'b1, 32'd0, 32'd1);
    check("R9 seconds wrap", {now_sec, now_sub}, {32'hFFFF_FFFF, 32'd999_999_999});

    // R11 coherent snapshot across a wrap
    roll_dec = 1'b1; inc = 8'd3;
    do_set(32'd4, 32'd999_999_995);
    @(negedge clk);
    check("R11 pre-snap live", {now_sec, now_sub}, {32'd4, 32'd999_999_998});
    snap_stb = 1'b1;
    @(negedge clk);
    snap_stb = 1'b0;
    check("R11 live after wrap", {now_sec, now_sub}, {32'd5, 32'd1});
    check("R11 snapshot", {snap_sec, snap_sub}, {32'd4, 32'd999_999_998});
    repeat (5) @(negedge clk);
    check("R11 snapshot held", {snap_sec, snap_sub}, {32'd4, 32'd999_999_998});

    report();
  end

endmodule